// File: doc/BRIEF.md
# CPU Status and Reset-Cause Register

This block is the 8-bit status register of a small microcontroller core. It holds six flags: a stack-available flag, a global interrupt block bit, a watchdog time-out flag, a power-down flag, and two reset-cause flags, one for power-on and one for brown-out. Each flag has its own set and clear sources. Some change only on hardware events and some only on software writes. The stack flag, once an overflow has cleared it, returns to 1 only on a device reset.

The core reads the register through `reg_rdata` and writes it with `reg_wr`/`reg_wdata`. Only the interrupt block bit and the two reset-cause bits accept writes. The interrupt block bit also drives `irq_block`, which the interrupt controller uses to mask every source. The power-on reset is asynchronous and active low. Brown-out and watchdog time-out arrive as one-cycle strobes. Both are device resets and are sampled on the rising clock edge like the other event strobes.

Top module: `cpusr_status_reg`

## Requirements
- R1: While `pwr_rst_n` is low, and after it is released with no other event, `reg_rdata` reads 8'h3C: stack-available, interrupt block, time-out and power-down are 1, and both reset-cause flags are 0. `irq_block` reads 1.
- R2: Bits 7 and 6 of `reg_rdata` always read 0.
- R3: Bit 5 (stack available) reads 0 in the cycle after `stk_ptr` is observed at all ones. If no overflow has occurred, it reads 1 again in the cycle after the pointer leaves all ones.
- R4: A `stk_push` while `stk_ptr` is all ones is an overflow. Bit 5 then stays 0 whatever the pointer does, until a device reset: `pwr_rst_n` low, `brownout_evt` or `wdog_timeout`.
- R5: Bit 4 (interrupt block) takes `reg_wdata[4]` on a write. `irq_block` equals bit 4 in every cycle, with no extra latency.
- R6: Bit 3 (time-out) becomes 0 after `wdog_timeout` and 1 after `clr_wdog`. When both occur in one cycle, `wdog_timeout` wins.
- R7: Bit 2 (power-down) becomes 0 after `sleep_exec` and 1 after `clr_wdog`. When both occur in one cycle, `sleep_exec` wins. `wdog_timeout` leaves bit 2 unchanged.
- R8: Bits 1 (power-on flag, 1 = no power-on reset) and 0 (brown-out flag, 1 = no brown-out) take `reg_wdata[1:0]` on a write. `brownout_evt` clears bit 0 and leaves bit 1 unchanged.
- R9: Writes do not change bits 5, 3 and 2.
- R10: `brownout_evt` sets time-out, power-down and interrupt block to 1 and restores the stack flag. `wdog_timeout` sets interrupt block to 1, restores the stack flag, and leaves both reset-cause bits unchanged.
- R11: When a hardware event and a write target the same bit in one cycle, the hardware event decides the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| pwr_rst_n | input | 1 | Asynchronous power-on reset, active low |
| brownout_evt | input | 1 | Brown-out reset strobe |
| wdog_timeout | input | 1 | Watchdog time-out strobe |
| clr_wdog | input | 1 | Clear-watchdog instruction strobe |
| sleep_exec | input | 1 | Sleep instruction strobe |
| stk_push | input | 1 | Stack push strobe |
| stk_ptr | input | SP_W | Current stack pointer |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| irq_block | output | 1 | Global interrupt mask |

## Verification
The collisions that matter are a software write arriving in the same cycle as a device-reset strobe, and a clear-watchdog strobe arriving with a watchdog time-out or with a sleep. Directed steps drive each pair together. For example, they write 1 to the brown-out flag and 0 to the interrupt block bit in the same cycle as `brownout_evt`. The flags that result are compared against the values the priority rules give. A randomized phase then drives all strobes and writes at once, and a behavioural model is compared against both outputs on every clock.

// File: rtl/cpusr_pkg.sv
package cpusr_pkg;
  localparam int REG_W   = 8;
  localparam int B_STK   = 5;
  localparam int B_GINT  = 4;
  localparam int B_TOUT  = 3;
  localparam int B_PDWN  = 2;
  localparam int B_PORF  = 1;
  localparam int B_BORF  = 0;

  typedef struct packed {
    logic stk_ok;
    logic gint;
    logic tout;
    logic pdwn;
    logic porf;
    logic borf;
  } flags_t;

  function automatic logic [REG_W-1:0] pack_status(input flags_t f);
    logic [REG_W-1:0] v;
    v = '0;
    v[B_STK]  = f.stk_ok;
    v[B_GINT] = f.gint;
    v[B_TOUT] = f.tout;
    v[B_PDWN] = f.pdwn;
    v[B_PORF] = f.porf;
    v[B_BORF] = f.borf;
    return v;
  endfunction

  function automatic logic ptr_at_top(input logic [15:0] ptr, input int width);
    logic r;
    r = 1'b1;
    for (int i = 0; i < width; i++) r &= ptr[i];
    return r;
  endfunction
endpackage

// File: rtl/cpusr_stack_mon.sv
module cpusr_stack_mon #(
  parameter int SP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dev_rst,
  input  logic            push,
  input  logic [SP_W-1:0] ptr,
  output logic            stk_ok
);
  import cpusr_pkg::*;

  logic full_now;
  logic ovf_evt;
  logic full_q;
  logic ovf_q;

  assign full_now = ptr_at_top(16'(ptr), SP_W);
  assign ovf_evt  = push & full_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      full_q <= full_now;
      if (dev_rst)      ovf_q <= 1'b0;
      else if (ovf_evt) ovf_q <= 1'b1;
    end
  end

  assign stk_ok = ~full_q & ~ovf_q;

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stk_ok && ovf_q && !dev_rst) |=> !stk_ok);
  // R3
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_now |=> !stk_ok);
  // R10
  dev_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rst && !full_now) |=> stk_ok);
endmodule

// File: rtl/cpusr_power_flags.sv
module cpusr_power_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic bor_evt,
  input  logic wdt_evt,
  input  logic clr_evt,
  input  logic slp_evt,
  output logic tout,
  output logic pdwn
);
  logic tout_q, pdwn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tout_q <= 1'b1;
      pdwn_q <= 1'b1;
    end else begin
      if (bor_evt)      tout_q <= 1'b1;
      else if (wdt_evt) tout_q <= 1'b0;
      else if (clr_evt) tout_q <= 1'b1;

      if (bor_evt)      pdwn_q <= 1'b1;
      else if (slp_evt) pdwn_q <= 1'b0;
      else if (clr_evt) pdwn_q <= 1'b1;
    end
  end

  assign tout = tout_q;
  assign pdwn = pdwn_q;

  // R6
  tout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_evt && !bor_evt) |=> !tout);
  // R7
  pdwn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slp_evt && !bor_evt) |=> !pdwn);
  // R10
  bor_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bor_evt |=> (tout && pdwn));
  // R9
  tout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bor_evt && !wdt_evt && !clr_evt) |=> $stable(tout));
endmodule

// File: rtl/cpusr_sw_bits.sv
module cpusr_sw_bits (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bor_evt,
  input  logic       dev_rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       gint,
  output logic       porf,
  output logic       borf
);
  import cpusr_pkg::*;

  logic gint_q, porf_q, borf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gint_q <= 1'b1;
      porf_q <= 1'b0;
      borf_q <= 1'b0;
    end else begin
      if (dev_rst)    gint_q <= 1'b1;
      else if (wr_en) gint_q <= wr_data[B_GINT];

      if (wr_en)      porf_q <= wr_data[B_PORF];

      if (bor_evt)    borf_q <= 1'b0;
      else if (wr_en) borf_q <= wr_data[B_BORF];
    end
  end

  assign gint = gint_q;
  assign porf = porf_q;
  assign borf = borf_q;

  // R11
  gint_hw_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |=> gint);
  // R11
  borf_hw_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bor_evt |=> !borf);
  // R8
  porf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(porf));
endmodule

// File: rtl/cpusr_status_reg.sv
module cpusr_status_reg #(
  parameter int SP_W = 4
) (
  input  logic            clk,
  input  logic            pwr_rst_n,
  input  logic            brownout_evt,
  input  logic            wdog_timeout,
  input  logic            clr_wdog,
  input  logic            sleep_exec,
  input  logic            stk_push,
  input  logic [SP_W-1:0] stk_ptr,
  input  logic            reg_wr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  output logic            irq_block
);
  import cpusr_pkg::*;

  logic   dev_rst_evt;
  flags_t fl;

  assign dev_rst_evt = brownout_evt | wdog_timeout;

  cpusr_stack_mon #(.SP_W(SP_W)) u_stk (
    .clk(clk), .rst_n(pwr_rst_n), .dev_rst(dev_rst_evt),
    .push(stk_push), .ptr(stk_ptr), .stk_ok(fl.stk_ok)
  );

  cpusr_power_flags u_pwr (
    .clk(clk), .rst_n(pwr_rst_n), .bor_evt(brownout_evt),
    .wdt_evt(wdog_timeout), .clr_evt(clr_wdog), .slp_evt(sleep_exec),
    .tout(fl.tout), .pdwn(fl.pdwn)
  );

  cpusr_sw_bits u_sw (
    .clk(clk), .rst_n(pwr_rst_n), .bor_evt(brownout_evt),
    .dev_rst(dev_rst_evt), .wr_en(reg_wr), .wr_data(reg_wdata),
    .gint(fl.gint), .porf(fl.porf), .borf(fl.borf)
  );

  assign reg_rdata = pack_status(fl);
  assign irq_block = fl.gint;

  // R8
  wdt_keeps_cause_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (wdog_timeout && !brownout_evt && !reg_wr) |=> $stable(reg_rdata[1:0]));
  // R7
  wdt_keeps_pdwn_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (wdog_timeout && !brownout_evt && !sleep_exec && !clr_wdog) |=> $stable(reg_rdata[2]));
endmodule

// File: tb/sim_cpusr_status_reg.sv
module sim_cpusr_status_reg;
  logic       clk = 1'b0;
  logic       pwr_rst_n = 1'b0;
  logic       brownout_evt = 1'b0, wdog_timeout = 1'b0, clr_wdog = 1'b0;
  logic       sleep_exec = 1'b0, stk_push = 1'b0, reg_wr = 1'b0;
  logic [3:0] stk_ptr = 4'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq_block;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  cpusr_status_reg #(.SP_W(4)) u0 (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .brownout_evt(brownout_evt),
    .wdog_timeout(wdog_timeout), .clr_wdog(clr_wdog), .sleep_exec(sleep_exec),
    .stk_push(stk_push), .stk_ptr(stk_ptr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_block(irq_block)
  );

  // behavioural reference
  int m_sticky, m_top, m_gi, m_to, m_pd, m_po, m_bo;
  always @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      m_sticky = 0; m_top = 0; m_gi = 1; m_to = 1; m_pd = 1; m_po = 0; m_bo = 0;
    end else begin
      m_top = (stk_ptr == 4'd15);
      if (brownout_evt || wdog_timeout) m_sticky = 0;
      else if (stk_push && stk_ptr == 4'd15) m_sticky = 1;
      if (reg_wr) begin
        m_gi = reg_wdata[4]; m_po = reg_wdata[1]; m_bo = reg_wdata[0];
      end
      if (clr_wdog) begin m_to = 1; m_pd = 1; end
      if (sleep_exec) m_pd = 0;
      if (wdog_timeout) begin m_to = 0; m_gi = 1; end
      if (brownout_evt) begin m_to = 1; m_pd = 1; m_gi = 1; m_bo = 0; end
    end
  end

  function automatic logic [7:0] model_val();
    logic [7:0] v;
    v = 8'h00;
    v[5] = (m_sticky == 0 && m_top == 0);
    v[4] = m_gi[0]; v[3] = m_to[0]; v[2] = m_pd[0];
    v[1] = m_po[0]; v[0] = m_bo[0];
    return v;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compare on every clock, sampled at the falling edge
  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, reg_rdata, model_val());
      check("R5", {7'd0, irq_block}, {7'd0, reg_rdata[4]});
    end
  end

  task automatic step();
    @(posedge clk);
    #5;
    brownout_evt = 0; wdog_timeout = 0; clr_wdog = 0; sleep_exec = 0;
    stk_push = 0; reg_wr = 0;
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1; reg_wdata = d;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog run hung actual=running expected=finished");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    #1;
    check("R1", reg_rdata, 8'h3C);
    check("R1", {7'd0, irq_block}, 8'h01);
    @(negedge clk); pwr_rst_n = 1;
    step();
    check("R1", reg_rdata, 8'h3C);
    check("R2", {6'd0, reg_rdata[7:6]}, 8'h00);

    cur_req = "R9";
    wr(8'hFF); step();
    check("R9", reg_rdata, 8'h3F);
    check("R2", {6'd0, reg_rdata[7:6]}, 8'h00);
    cur_req = "R5";
    wr(8'h00); step();
    check("R5", reg_rdata, 8'h2C);
    check("R5", {7'd0, irq_block}, 8'h00);

    cur_req = "R3";
    stk_ptr = 4'hF; step();
    check("R3", {7'd0, reg_rdata[5]}, 8'h00);
    stk_ptr = 4'h3; step();
    check("R3", {7'd0, reg_rdata[5]}, 8'h01);

    cur_req = "R4";
    stk_ptr = 4'hF; stk_push = 1; step();
    stk_ptr = 4'h0; step();
    check("R4", {7'd0, reg_rdata[5]}, 8'h00);
    stk_ptr = 4'h2; wr(8'h03); step();
    step(); step();
    check("R4", {7'd0, reg_rdata[5]}, 8'h00);
    check("R8", {6'd0, reg_rdata[1:0]}, 8'h03);

    cur_req = "R10";
    wdog_timeout = 1; step();
    check("R4", {7'd0, reg_rdata[5]}, 8'h01);
    check("R6", {7'd0, reg_rdata[3]}, 8'h00);
    check("R10", {7'd0, irq_block}, 8'h01);
    check("R10", {6'd0, reg_rdata[1:0]}, 8'h03);

    cur_req = "R6";
    clr_wdog = 1; step();
    check("R6", {6'd0, reg_rdata[3:2]}, 8'h03);
    cur_req = "R7";
    sleep_exec = 1; step();
    check("R7", {7'd0, reg_rdata[2]}, 8'h00);
    clr_wdog = 1; step();
    check("R7", {7'd0, reg_rdata[2]}, 8'h01);
    clr_wdog = 1; sleep_exec = 1; step();
    check("R7", {7'd0, reg_rdata[2]}, 8'h00);
    clr_wdog = 1; step();
    cur_req = "R6";
    wdog_timeout = 1; clr_wdog = 1; step();
    check("R6", {7'd0, reg_rdata[3]}, 8'h00);
    check("R7", {7'd0, reg_rdata[2]}, 8'h01);
    sleep_exec = 1; step();

    cur_req = "R8";
    brownout_evt = 1; step();
    check("R8", {6'd0, reg_rdata[1:0]}, 8'h02);
    check("R10", reg_rdata, 8'h3E);

    cur_req = "R11";
    wr(8'h03); step();
    check("R5", {7'd0, irq_block}, 8'h00);
    brownout_evt = 1; wr(8'h03); step();
    check("R11", {7'd0, reg_rdata[0]}, 8'h00);
    check("R11", {7'd0, irq_block}, 8'h01);
    check("R11", {7'd0, reg_rdata[1]}, 8'h01);
    wdog_timeout = 1; wr(8'h00); step();
    check("R11", {7'd0, irq_block}, 8'h01);

    cur_req = "R11";
    for (int i = 0; i < 400; i++) begin
      brownout_evt = ($urandom_range(0, 15) == 0);
      wdog_timeout = ($urandom_range(0, 9) == 0);
      clr_wdog     = ($urandom_range(0, 3) == 0);
      sleep_exec   = ($urandom_range(0, 3) == 0);
      stk_push     = ($urandom_range(0, 2) == 0);
      stk_ptr      = ($urandom_range(0, 2) == 0) ? 4'hF : 4'($urandom_range(0, 15));
      reg_wr       = ($urandom_range(0, 2) == 0);
      reg_wdata    = 8'($urandom_range(0, 255));
      step();
    end

    cur_req = "R1";
    pwr_rst_n = 0; #2;
    check("R1", reg_rdata, 8'h3C);
    @(negedge clk); pwr_rst_n = 1; stk_ptr = 4'h0;
    step();
    check("R1", reg_rdata, 8'h3C);
    finish_run();
  end
endmodule